// File: doc/BRIEF.md
# Block Floating Point IQ Sample Restorer

This block takes a byte stream of block-floating-point records and restores the 16-bit signed I/Q samples they encode. Each record carries one shared scale byte and then 128 mantissas packed MSB first at a configured width of 8, 9, 10 or 12 bits. The block unpacks every mantissa, including those that straddle byte boundaries, and rescales it by the record's scale byte. It emits one sample per cycle on a valid-only output stream, in the same interleaved I/Q order the mantissas arrive in.

A request is a run of 1, 4 or 16 records placed back to back on the input. The mantissa width and the record count are sampled from the configuration pins when the first scale byte of a request is accepted. They stay fixed until that request ends. At each record boundary the byte input stalls until every sample of the finished record has left the unpacker, so one record's scale never mixes with the next one's mantissas.

Top module: `bfp_iq_unpacker`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `out_valid` is 0 and `in_ready` is 1. A reset in the middle of a request drops the partial record.
- R2: The first accepted byte of a record is its scale byte, and the next 16*width bytes are its mantissas. Each record yields exactly 128 samples, and `out_blk_last` is high on the 128th sample only.
- R3: Mantissas are read from the byte stream MSB first, with the first byte's bit 7 as the top bit of the first mantissa. Fields that cross a byte boundary continue into the next byte. Samples come out in mantissa order.
- R4: For widths 9, 10 and 12 (`cfg_width` 2'b01, 2'b10, 2'b11), the mantissa is placed in the top bits of a 16-bit word, and the output is that word arithmetically shifted right by (16 - width - scale).
- R5: For width 8 (`cfg_width` 2'b00), the output is the mantissa byte sign-extended to 16 bits and shifted left by the scale.
- R6: A scale byte above 16 - width acts as 16 - width, so the output equals the mantissa shifted left by 16 - width.
- R7: `cfg_recs` selects records per request: 2'b00 gives 1, 2'b01 gives 4, and 2'b10 or 2'b11 gives 16. `out_req_last` is high only on the final sample of the final record.
- R8: After the last mantissa byte of a record is accepted, `in_ready` stays low until the cycle after that record's final sample is produced.
- R9: `cfg_width` and `cfg_recs` are sampled only when the first scale byte of a request is accepted. Changes to them later in the request have no effect on that request's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 2 | Mantissa width code: 0=8, 1=9, 2=10, 3=12 bits |
| cfg_recs | input | 2 | Records per request code: 0=1, 1=4, 2 or 3=16 |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output sample valid |
| out_data | output | 16 | Restored signed sample |
| out_blk_last | output | 1 | Final sample of a record |
| out_req_last | output | 1 | Final sample of a request |

## Verification
The stimulus puts the most negative, most positive and all-ones mantissas at the start of every record, so a rescale that loses the sign (logical instead of arithmetic shift) or drops the top bit shows up at once. The 9- and 10-bit cases make almost every field cross a byte boundary, so an unpacker that takes bits in the wrong order or at the wrong offset corrupts nearly all samples. Scale bytes above the per-width limit would yield shifted-out or wrapped values if the clamp were missing. The configuration pins are changed right after each request starts; a design that read them live would switch width in the middle of a record. A design that accepted the next scale byte too early would clip the stall check taken right after each final mantissa byte.

// File: rtl/bfp_dec_pkg.sv
package bfp_dec_pkg;

  localparam int SAMPLE_W = 16;
  localparam int WBITS    = $clog2(SAMPLE_W + 1);

  typedef enum logic [1:0] {
    MW_8  = 2'd0,
    MW_9  = 2'd1,
    MW_10 = 2'd2,
    MW_12 = 2'd3
  } mant_w_e;

  typedef enum logic [1:0] {
    ST_SCALE = 2'd0,
    ST_BODY  = 2'd1,
    ST_DRAIN = 2'd2
  } rec_st_e;

  function automatic logic [WBITS-1:0] mant_bits(mant_w_e w);
    case (w)
      MW_8:    return WBITS'(8);
      MW_9:    return WBITS'(9);
      MW_10:   return WBITS'(10);
      default: return WBITS'(12);
    endcase
  endfunction

  function automatic int rec_total(logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/bfp_bit_accum.sv
module bfp_bit_accum
  import bfp_dec_pkg::*;
#(
  parameter int ACC_W = 24,
  parameter int IN_W  = 8,
  parameter int OUT_W = SAMPLE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WBITS-1:0]  fld_bits,
  input  logic              push,
  input  logic [IN_W-1:0]   in_byte,
  output logic              can_push,
  output logic              pop,
  output logic [OUT_W-1:0]  field_word
);

  localparam int CNT_W = $clog2(ACC_W + 1);
  localparam int ROOM  = ACC_W - IN_W;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] left;
  logic [ACC_W-1:0] shifted;
  logic [ACC_W-1:0] ins;
  logic [OUT_W-1:0] hi_mask;

  // A field is ready once enough bits are held; pop does not depend on push.
  always_comb begin
    pop      = cnt_q >= CNT_W'(fld_bits);
    left     = pop ? (cnt_q - CNT_W'(fld_bits)) : cnt_q;
    can_push = left <= CNT_W'(ROOM);
    shifted  = pop ? (acc_q << fld_bits) : acc_q;
    ins      = {in_byte, {ROOM{1'b0}}} >> left;
    acc_d    = push ? (shifted | ins) : shifted;
    cnt_d    = push ? (left + CNT_W'(IN_W)) : left;
    hi_mask  = ~({OUT_W{1'b1}} >> fld_bits);
    field_word = acc_q[ACC_W-1 -: OUT_W] & hi_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (push || pop) begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/bfp_rec_ctrl.sv
module bfp_rec_ctrl
  import bfp_dec_pkg::*;
#(
  parameter int ELEMS    = 128,
  parameter int IN_W     = 8,
  parameter int MAX_RECS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [IN_W-1:0]   in_data,
  input  logic [1:0]        cfg_width,
  input  logic [1:0]        cfg_recs,
  input  logic              can_push,
  input  logic              pop,
  output logic              in_ready,
  output logic              push,
  output logic [WBITS-1:0]  fld_bits,
  output logic [WBITS-1:0]  max_shift,
  output logic [IN_W-1:0]   scale,
  output logic              blk_end,
  output logic              req_end
);

  localparam int SCNT_W = $clog2(ELEMS);
  localparam int BPB    = ELEMS / IN_W;
  localparam int BCNT_W = $clog2(BPB * SAMPLE_W + 1);
  localparam int RCNT_W = $clog2(MAX_RECS) + 1;

  rec_st_e            st_q, st_d;
  logic [BCNT_W-1:0]  bcnt_q, bcnt_d;
  logic [SCNT_W-1:0]  scnt_q, scnt_d;
  logic [RCNT_W-1:0]  rcnt_q, rcnt_d;
  mant_w_e            wsel_q;
  logic [1:0]         rsel_q;
  logic [IN_W-1:0]    scale_q;
  logic [BCNT_W-1:0]  rec_bytes;
  logic               hs, take_scale, first_rec, rec_last;

  always_comb begin
    fld_bits   = mant_bits(wsel_q);
    max_shift  = WBITS'(SAMPLE_W) - fld_bits;
    rec_bytes  = BCNT_W'(fld_bits) * BCNT_W'(BPB);
    in_ready   = (st_q == ST_SCALE) || ((st_q == ST_BODY) && can_push);
    hs         = in_valid && in_ready;
    push       = hs && (st_q == ST_BODY);
    take_scale = hs && (st_q == ST_SCALE);
    first_rec  = (rcnt_q == '0);
    rec_last   = (rcnt_q == RCNT_W'(rec_total(rsel_q) - 1));
    blk_end    = pop && (scnt_q == SCNT_W'(ELEMS - 1));
    req_end    = blk_end && rec_last;
    scale      = scale_q;
  end

  // next-state
  always_comb begin
    st_d   = st_q;
    bcnt_d = bcnt_q;
    scnt_d = scnt_q;
    rcnt_d = rcnt_q;
    if (pop) scnt_d = blk_end ? '0 : scnt_q + 1'b1;
    case (st_q)
      ST_SCALE: begin
        if (take_scale) begin
          st_d   = ST_BODY;
          bcnt_d = '0;
        end
      end
      ST_BODY: begin
        if (push) begin
          bcnt_d = bcnt_q + 1'b1;
          if (bcnt_q == rec_bytes - 1'b1) st_d = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (blk_end) begin
          st_d   = ST_SCALE;
          rcnt_d = rec_last ? '0 : rcnt_q + 1'b1;
        end
      end
      default: st_d = ST_SCALE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_SCALE;
      bcnt_q <= '0;
      scnt_q <= '0;
      rcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      bcnt_q <= bcnt_d;
      scnt_q <= scnt_d;
      rcnt_q <= rcnt_d;
    end
  end

  // configuration is captured only with the first scale byte of a request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsel_q <= MW_8;
      rsel_q <= '0;
    end else if (take_scale && first_rec) begin
      wsel_q <= mant_w_e'(cfg_width);
      rsel_q <= cfg_recs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scale_q <= '0;
    else if (take_scale) scale_q <= in_data;
  end

endmodule

// File: rtl/bfp_rescale.sv
module bfp_rescale
  import bfp_dec_pkg::*;
#(
  parameter int IN_W         = 8,
  parameter bit SPLIT_NARROW = 1'b1
) (
  input  logic [SAMPLE_W-1:0] field_word,
  input  logic [IN_W-1:0]     scale,
  input  logic [WBITS-1:0]    max_shift,
  output logic [SAMPLE_W-1:0] sample
);

  logic [WBITS-1:0]    e_cl;
  logic [WBITS-1:0]    rsh;
  logic [SAMPLE_W-1:0] wide;

  always_comb begin
    e_cl = (scale > IN_W'(max_shift)) ? max_shift : WBITS'(scale);
    rsh  = max_shift - e_cl;
    wide = $signed(field_word) >>> rsh;
  end

  generate
    if (SPLIT_NARROW) begin : g_split
      logic                narrow_sel;
      logic [SAMPLE_W-1:0] narrow;
      always_comb begin
        narrow_sel = (max_shift == WBITS'(SAMPLE_W - IN_W));
        narrow = {{(SAMPLE_W-IN_W){field_word[SAMPLE_W-1]}},
                  field_word[SAMPLE_W-1 -: IN_W]} << e_cl;
        sample = narrow_sel ? narrow : wide;
      end
    end else begin : g_unified
      assign sample = wide;
    end
  endgenerate

endmodule

// File: rtl/bfp_iq_unpacker.sv
module bfp_iq_unpacker
  import bfp_dec_pkg::*;
#(
  parameter int ELEMS        = 128,
  parameter int IN_W         = 8,
  parameter int ACC_W        = 24,
  parameter int MAX_RECS     = 16,
  parameter bit SPLIT_NARROW = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cfg_width,
  input  logic [1:0]          cfg_recs,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [IN_W-1:0]     in_data,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_data,
  output logic                out_blk_last,
  output logic                out_req_last
);

  logic                can_push, pop, push, blk_end, req_end;
  logic [WBITS-1:0]    fld_bits, max_shift;
  logic [IN_W-1:0]     scale;
  logic [SAMPLE_W-1:0] field_word, sample;

  logic                vld_q, blk_q, req_q;
  logic [SAMPLE_W-1:0] data_q;

  bfp_rec_ctrl #(.ELEMS(ELEMS), .IN_W(IN_W), .MAX_RECS(MAX_RECS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .cfg_width(cfg_width), .cfg_recs(cfg_recs), .can_push(can_push), .pop(pop),
    .in_ready(in_ready), .push(push), .fld_bits(fld_bits), .max_shift(max_shift),
    .scale(scale), .blk_end(blk_end), .req_end(req_end)
  );

  bfp_bit_accum #(.ACC_W(ACC_W), .IN_W(IN_W), .OUT_W(SAMPLE_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .fld_bits(fld_bits), .push(push), .in_byte(in_data),
    .can_push(can_push), .pop(pop), .field_word(field_word)
  );

  bfp_rescale #(.IN_W(IN_W), .SPLIT_NARROW(SPLIT_NARROW)) u_scale (
    .field_word(field_word), .scale(scale), .max_shift(max_shift), .sample(sample)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      blk_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      vld_q <= pop;
      blk_q <= blk_end;
      req_q <= req_end;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else if (pop) data_q <= sample;
  end

  assign out_valid    = vld_q;
  assign out_data     = data_q;
  assign out_blk_last = blk_q;
  assign out_req_last = req_q;

endmodule

// File: rtl/bfp_iq_unpacker_chk.sv
module bfp_iq_unpacker_chk #(
  parameter int ELEMS = 128
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_blk_last,
  input logic out_req_last
);

  localparam int OCNT_W = $clog2(ELEMS);
  logic [OCNT_W-1:0] ocnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ocnt_q <= '0;
    else if (out_valid) ocnt_q <= ocnt_q + 1'b1;
  end

  // R1: reset leaves the output idle
  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R2: record end flag only on a valid sample
  a_r2_flag_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_blk_last |-> out_valid);

  // R2: record end flag exactly on every 128th sample
  a_r2_blk_cadence: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_blk_last == (ocnt_q == OCNT_W'(ELEMS - 1))));

  // R7: request end only coincides with a record end
  a_r7_req_in_blk: assert property (@(posedge clk) disable iff (!rst_n)
    out_req_last |-> out_blk_last);

  // R8: no byte taken while the record's last sample is being produced
  a_r8_stall_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    out_blk_last |-> !$past(in_valid && in_ready));

endmodule

bind bfp_iq_unpacker bfp_iq_unpacker_chk #(.ELEMS(ELEMS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_blk_last(out_blk_last), .out_req_last(out_req_last)
);

// File: tb/tb_bfp_iq_unpacker.sv
`timescale 1ns/1ps
module tb_bfp_iq_unpacker;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_width, cfg_recs;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_data;
  logic        out_valid;
  logic [15:0] out_data;
  logic        out_blk_last, out_req_last;

  always #2 clk = ~clk;  // 250 MHz

  bfp_iq_unpacker dut (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_recs(cfg_recs),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data),
    .out_blk_last(out_blk_last), .out_req_last(out_req_last)
  );

  int checks = 0;
  int fails  = 0;
  logic signed [15:0] exp_s [2048];
  int    n_exp = 0;
  int    got   = 0;
  int    bl_cnt = 0;
  int    rl_cnt = 0;
  bit    mon_en = 1'b0;
  string tag = "";

  // vector table: width code, record code, base scale, seed, expected samples
  localparam int NV = 8;
  localparam logic [1:0] V_W   [NV] = '{2'd0, 2'd0, 2'd1, 2'd2, 2'd3, 2'd3, 2'd0, 2'd1};
  localparam logic [1:0] V_R   [NV] = '{2'd0, 2'd1, 2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 2'd3};
  localparam int         V_E   [NV] = '{0, 3, 2, 5, 4, 9, 12, 5};
  localparam int         V_S   [NV] = '{1, 7, 3, 11, 5, 9, 2, 13};
  localparam int         V_N   [NV] = '{128, 512, 128, 512, 128, 128, 128, 2048};

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int wbits(input logic [1:0] c);
    case (c)
      2'd0: return 8;
      2'd1: return 9;
      2'd2: return 10;
      default: return 12;
    endcase
  endfunction

  function automatic int mant(input int w, input int seed, input int r, input int k);
    if (k == 0) return 1 << (w - 1);
    if (k == 1) return (1 << (w - 1)) - 1;
    if (k == 2) return (1 << w) - 1;
    return (seed * 131 + k * 37 + r * 59 + k * k * 7) & ((1 << w) - 1);
  endfunction

  // monitor: sample outputs away from the active edge
  always @(negedge clk) begin
    if (rst_n && mon_en && out_valid) begin
      if (got < n_exp) begin
        chk(out_data == exp_s[got], tag, $signed(out_data), exp_s[got]);
        // R2: record end on every 128th sample
        chk(out_blk_last == ((got % 128) == 127), "R2", out_blk_last, (got % 128) == 127);
        // R7: request end on the final sample only
        chk(out_req_last == (got == n_exp - 1), "R7", out_req_last, got == n_exp - 1);
      end else begin
        chk(1'b0, "R7", got, n_exp);
      end
      if (out_blk_last) bl_cnt++;
      if (out_req_last) rl_cnt++;
      got++;
    end
  end

  task automatic push_byte(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_request(input logic [1:0] wc, input logic [1:0] rc,
                             input int base_e, input int seed, input int n_tab);
    int w, nrec, e, ecl, raw, val, pos, nbytes;
    logic [7:0] bytes_b [192];
    w    = wbits(wc);
    nrec = (rc == 2'd0) ? 1 : (rc == 2'd1) ? 4 : 16;
    chk(nrec * 128 == n_tab, "R7", nrec * 128, n_tab);
    n_exp = nrec * 128; got = 0; bl_cnt = 0; rl_cnt = 0; mon_en = 1'b1;
    if (base_e + 1 > 16 - w) tag = "R6";
    else if (w == 8) tag = "R5 R3 R9";
    else tag = "R4 R3 R9";
    nbytes = 16 * w;
    for (int r = 0; r < nrec; r++) begin
      e   = base_e + (r & 1);
      ecl = (e > 16 - w) ? 16 - w : e;
      for (int i = 0; i < 192; i++) bytes_b[i] = 8'h00;
      for (int k = 0; k < 128; k++) begin
        raw = mant(w, seed, r, k);
        val = (raw >= (1 << (w - 1))) ? raw - (1 << w) : raw;
        exp_s[r * 128 + k] = 16'(val * (1 << ecl));
        for (int j = 0; j < w; j++) begin
          pos = k * w + j;
          bytes_b[pos >> 3][7 - (pos & 7)] = 1'((raw >> (w - 1 - j)) & 1);
        end
      end
      if (r == 0) begin cfg_width = wc; cfg_recs = rc; end
      push_byte(8'(e));
      // R9: configuration disturbed once the request has started
      if (r == 0) begin cfg_width = ~wc; cfg_recs = ~rc; end
      for (int i = 0; i < nbytes; i++) push_byte(bytes_b[i]);
      // R8: stalled right after the record's final mantissa byte
      chk(in_ready == 1'b0, "R8", in_ready, 0);
    end
    for (int t = 0; t < 400 && got < n_exp; t++) @(negedge clk);
    chk(got == n_exp, "R2", got, n_exp);
    chk(bl_cnt == nrec, "R2", bl_cnt, nrec);
    chk(rl_cnt == 1, "R7", rl_cnt, 1);
    mon_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; cfg_width = '0; cfg_recs = '0;
    repeat (3) @(negedge clk);
    // R1: idle state during reset
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(in_ready == 1'b1, "R1", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(in_ready == 1'b1, "R1", in_ready, 1);

    for (int v = 0; v < NV; v++) run_request(V_W[v], V_R[v], V_E[v], V_S[v], V_N[v]);

    // R1: reset in the middle of a record drops it
    cfg_width = 2'd0; cfg_recs = 2'd0;
    push_byte(8'd1);
    push_byte(8'h55); push_byte(8'hAA); push_byte(8'h0F);
    rst_n = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(in_ready == 1'b1, "R1", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", in_ready, 1);
    // recovery: full 10-bit single record after the abort
    run_request(2'd2, 2'd0, 1, 21, 128);

    finish_run();
  end

endmodule